// File: doc/BRIEF.md
# Debug Access Authentication Gate

This block guards the write path into a debug register file. Every debugger write passes through it. When the configuration demands authentication, the gate drops writes to protected registers until the debugger has proven knowledge of a shared secret. The gate itself owns two registers: the control word and the authentication-data word. In the control word only the activate bit responds before authentication succeeds.

To authenticate, the debugger reads the current challenge from the authentication-data address. It then writes back the 32-bit wrapping sum of that challenge and the secret. A correct response sets the authenticated status. A wrong response clears the status and replaces the challenge with a fresh value from a free-running LFSR. Clearing the activate bit also clears the status when authentication is required. When authentication is not required, the block reports authenticated from reset and forwards everything.

Writes to other addresses leave the gate combinationally, in the same cycle, on a forward port. Reads of the two owned addresses are answered through a combinational read port.

Top module: `dbg_auth_gate`

## Requirements
- R1: After reset, authenticated_o is 0 when AUTH_REQ=1, every control output is 0, and a read of the authentication-data address returns the SEED parameter.
- R2: A write to any address other than CTL_ADDR or AUTH_ADDR appears on fwd_en_o/fwd_addr_o/fwd_data_o in the same cycle only while authenticated_o is 1; otherwise fwd_en_o stays 0. Writes to the two owned addresses are never forwarded.
- R3: Every write to CTL_ADDR loads bit 0 of the data into ctl_active_o on the next clock, whether or not the block is authenticated.
- R4: A write to CTL_ADDR with bit 0 set loads the other fields only if authenticated_o was 1 before the write. Otherwise those fields keep their values. The fields are halt bit 1, resume bit 2, hart reset bit 3, system reset bit 4, and hart select at bits [8 +: HSEL_W].
- R5: A write to CTL_ADDR with bit 0 clear sets every other control field to 0.
- R6: With AUTH_REQ=1, a write to AUTH_ADDR whose data equals challenge + SECRET modulo 2^32 sets authenticated_o on the next clock and leaves the challenge unchanged.
- R7: With AUTH_REQ=1, any other write to AUTH_ADDR clears authenticated_o. It also loads the challenge from a 32-bit Galois LFSR (right shift, mask 0x80200003, seeded with SEED at reset) that steps every cycle. The new challenge then accepts its own response.
- R8: Reading AUTH_ADDR returns the challenge. Reading CTL_ADDR returns the control fields at the bit positions of R3/R4, with the other bits 0. Any other read address returns 0.
- R9: With AUTH_REQ=1, a write to CTL_ADDR with bit 0 clear clears authenticated_o.
- R10: With AUTH_REQ=0, authenticated_o is 1 at all times after reset, writes to AUTH_ADDR change neither status nor challenge, and all other addresses are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Debugger write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read address for the owned registers |
| rd_data_o | output | 32 | Read data (challenge, control word or 0) |
| fwd_en_o | output | 1 | Forwarded write strobe to protected registers |
| fwd_addr_o | output | ADDR_W | Forwarded write address |
| fwd_data_o | output | 32 | Forwarded write data |
| authenticated_o | output | 1 | Authentication status |
| ctl_active_o | output | 1 | Debug activate bit |
| ctl_halt_o | output | 1 | Halt request |
| ctl_resume_o | output | 1 | Resume request |
| ctl_hart_rst_o | output | 1 | Hart reset request |
| ctl_sys_rst_o | output | 1 | System reset request |
| ctl_hartsel_o | output | HSEL_W | Selected hart |

## Verification
The hardest state to reach from the ports is a correct response to a regenerated challenge. The new value depends on the exact cycle at which the failing write lands in the free-running LFSR, so the bench cannot predict it. The stimulus therefore forces a mismatch, reads the new challenge back through the read port, and answers it with challenge plus secret. The bench also checks that the new value differs from the seed. A second instance built without authentication takes the same stimulus, which shows that its status and challenge never move.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;
  localparam int unsigned DW = 32;
  // control word bit positions
  localparam int unsigned CTL_ACT_BIT  = 0;
  localparam int unsigned CTL_HALT_BIT = 1;
  localparam int unsigned CTL_RES_BIT  = 2;
  localparam int unsigned CTL_HRST_BIT = 3;
  localparam int unsigned CTL_SRST_BIT = 4;
  localparam int unsigned CTL_HSEL_LSB = 8;
  localparam logic [DW-1:0] LFSR_MASK = 32'h8020_0003;

  typedef struct packed {
    logic halt;
    logic resume;
    logic hart_rst;
    logic sys_rst;
  } ctl_req_t;
endpackage

// File: rtl/dbg_auth_lfsr.sv
module dbg_auth_lfsr
  import dbg_auth_pkg::*;
#(
  parameter logic [DW-1:0] SEED = 32'h1ACE_B00C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] state_o
);
  logic [DW-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEED;
    else         st_q <= {1'b0, st_q[DW-1:1]} ^ (st_q[0] ? LFSR_MASK : '0);
  end

  assign state_o = st_q;
endmodule

// File: rtl/dbg_auth_core.sv
module dbg_auth_core
  import dbg_auth_pkg::*;
#(
  parameter bit            AUTH_REQ = 1'b1,
  parameter logic [DW-1:0] SEED     = 32'h1ACE_B00C,
  parameter logic [DW-1:0] SECRET   = 32'h5EC2_E7A1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          resp_wr_i,
  input  logic [DW-1:0] resp_i,
  input  logic          deact_i,
  input  logic [DW-1:0] rand_i,
  output logic          authed_o,
  output logic [DW-1:0] chal_o
);
  logic          authed_q;
  logic [DW-1:0] chal_q;
  logic          match;

  assign match = (resp_i == chal_q + SECRET);

  generate
    if (AUTH_REQ) begin : g_req
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          authed_q <= 1'b0;
          chal_q   <= SEED;
        end else if (resp_wr_i) begin
          authed_q <= match;
          if (!match) chal_q <= rand_i;
        end else if (deact_i) begin
          authed_q <= 1'b0;
        end
      end
    end else begin : g_open
      logic unused_in;
      assign unused_in = ^{resp_wr_i, resp_i, deact_i, rand_i, match};
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          authed_q <= 1'b1;
          chal_q   <= SEED;
        end else begin
          authed_q <= 1'b1;
          chal_q   <= chal_q;
        end
      end
    end
  endgenerate

  assign authed_o = authed_q;
  assign chal_o   = chal_q;
endmodule

// File: rtl/dbg_auth_ctl.sv
module dbg_auth_ctl
  import dbg_auth_pkg::*;
#(
  parameter int unsigned HSEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              act_i,
  input  ctl_req_t          req_i,
  input  logic [HSEL_W-1:0] hsel_i,
  input  logic              authed_i,
  output logic              act_o,
  output ctl_req_t          req_o,
  output logic [HSEL_W-1:0] hsel_o
);
  logic              act_q;
  ctl_req_t          req_q;
  logic [HSEL_W-1:0] hsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      req_q  <= '0;
      hsel_q <= '0;
    end else if (wr_i) begin
      act_q <= act_i;
      if (!act_i) begin
        req_q  <= '0;
        hsel_q <= '0;
      end else if (authed_i) begin
        req_q  <= req_i;
        hsel_q <= hsel_i;
      end
    end
  end

  assign act_o  = act_q;
  assign req_o  = req_q;
  assign hsel_o = hsel_q;
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
  import dbg_auth_pkg::*;
#(
  parameter bit              ADDR_W    = 7,
  parameter int unsigned     HSEL_W    = 4,
  parameter bit              AUTH_REQ  = 1'b1,
  parameter logic [6:0]      CTL_ADDR  = 7'h10,
  parameter logic [6:0]      AUTH_ADDR = 7'h30,
  parameter logic [DW-1:0]   SEED      = 32'h1ACE_B00C,
  parameter logic [DW-1:0]   SECRET    = 32'h5EC2_E7A1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [6:0]        wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [6:0]        rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              fwd_en_o,
  output logic [6:0]        fwd_addr_o,
  output logic [DW-1:0]     fwd_data_o,
  output logic              authenticated_o,
  output logic              ctl_active_o,
  output logic              ctl_halt_o,
  output logic              ctl_resume_o,
  output logic              ctl_hart_rst_o,
  output logic              ctl_sys_rst_o,
  output logic [HSEL_W-1:0] ctl_hartsel_o
);
  logic          hit_ctl, hit_auth, authed;
  logic [DW-1:0] lfsr, chal;
  ctl_req_t      req_in, req_q;
  logic          act_q;
  logic [HSEL_W-1:0] hsel_q;

  assign hit_ctl  = wr_en_i && (wr_addr_i == CTL_ADDR);
  assign hit_auth = wr_en_i && (wr_addr_i == AUTH_ADDR);

  assign req_in = '{halt:     wr_data_i[CTL_HALT_BIT],
                    resume:   wr_data_i[CTL_RES_BIT],
                    hart_rst: wr_data_i[CTL_HRST_BIT],
                    sys_rst:  wr_data_i[CTL_SRST_BIT]};

  dbg_auth_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_o(lfsr)
  );

  dbg_auth_core #(.AUTH_REQ(AUTH_REQ), .SEED(SEED), .SECRET(SECRET)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .resp_wr_i(hit_auth), .resp_i(wr_data_i),
    .deact_i(hit_ctl && !wr_data_i[CTL_ACT_BIT]),
    .rand_i(lfsr), .authed_o(authed), .chal_o(chal)
  );

  dbg_auth_ctl #(.HSEL_W(HSEL_W)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(hit_ctl), .act_i(wr_data_i[CTL_ACT_BIT]), .req_i(req_in),
    .hsel_i(wr_data_i[CTL_HSEL_LSB +: HSEL_W]), .authed_i(authed),
    .act_o(act_q), .req_o(req_q), .hsel_o(hsel_q)
  );

  // forward path: combinational, gated per address
  assign fwd_en_o   = wr_en_i && authed && !hit_ctl && !hit_auth;
  assign fwd_addr_o = wr_addr_i;
  assign fwd_data_o = wr_data_i;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AUTH_ADDR) begin
      rd_data_o = chal;
    end else if (rd_addr_i == CTL_ADDR) begin
      rd_data_o[CTL_ACT_BIT]  = act_q;
      rd_data_o[CTL_HALT_BIT] = req_q.halt;
      rd_data_o[CTL_RES_BIT]  = req_q.resume;
      rd_data_o[CTL_HRST_BIT] = req_q.hart_rst;
      rd_data_o[CTL_SRST_BIT] = req_q.sys_rst;
      rd_data_o[CTL_HSEL_LSB +: HSEL_W] = hsel_q;
    end
  end

  assign authenticated_o = authed;
  assign ctl_active_o    = act_q;
  assign ctl_halt_o      = req_q.halt;
  assign ctl_resume_o    = req_q.resume;
  assign ctl_hart_rst_o  = req_q.hart_rst;
  assign ctl_sys_rst_o   = req_q.sys_rst;
  assign ctl_hartsel_o   = hsel_q;
endmodule

module dbg_auth_gate_chk
  import dbg_auth_pkg::*;
#(
  parameter int unsigned   HSEL_W    = 4,
  parameter bit            AUTH_REQ  = 1'b1,
  parameter logic [6:0]    CTL_ADDR  = 7'h10,
  parameter logic [6:0]    AUTH_ADDR = 7'h30,
  parameter logic [DW-1:0] SECRET    = 32'h5EC2_E7A1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [6:0]        wr_addr_i,
  input logic [DW-1:0]     wr_data_i,
  input logic              fwd_en_o,
  input logic              authenticated_o,
  input logic              ctl_active_o,
  input logic              ctl_halt_o,
  input logic              ctl_resume_o,
  input logic              ctl_hart_rst_o,
  input logic              ctl_sys_rst_o,
  input logic [HSEL_W-1:0] ctl_hartsel_o,
  input logic [DW-1:0]     chal
);
  logic ctl_w, auth_w;
  logic [HSEL_W+3:0] fields;
  assign ctl_w  = wr_en_i && wr_addr_i == CTL_ADDR;
  assign auth_w = wr_en_i && wr_addr_i == AUTH_ADDR;
  assign fields = {ctl_halt_o, ctl_resume_o, ctl_hart_rst_o, ctl_sys_rst_o, ctl_hartsel_o};

  p_no_fwd_unauth_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!authenticated_o || ctl_w || auth_w) |-> !fwd_en_o);
  p_active_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_w |=> ctl_active_o == $past(wr_data_i[0]));
  p_fields_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && wr_data_i[0] && !authenticated_o) |=> $stable(fields));
  p_fields_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && !wr_data_i[0]) |=> fields == '0);
  p_match_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (AUTH_REQ && auth_w && wr_data_i == chal + SECRET) |=> authenticated_o && $stable(chal));
  p_miss_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (AUTH_REQ && auth_w && wr_data_i != chal + SECRET) |=> !authenticated_o);
  p_chal_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auth_w |=> $stable(chal));
  p_deact_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (AUTH_REQ && ctl_w && !wr_data_i[0]) |=> !authenticated_o);
  p_open_always_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !AUTH_REQ |-> authenticated_o);
endmodule

bind dbg_auth_gate dbg_auth_gate_chk #(
  .HSEL_W(HSEL_W), .AUTH_REQ(AUTH_REQ), .CTL_ADDR(CTL_ADDR),
  .AUTH_ADDR(AUTH_ADDR), .SECRET(SECRET)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .fwd_en_o(fwd_en_o), .authenticated_o(authenticated_o),
  .ctl_active_o(ctl_active_o), .ctl_halt_o(ctl_halt_o), .ctl_resume_o(ctl_resume_o),
  .ctl_hart_rst_o(ctl_hart_rst_o), .ctl_sys_rst_o(ctl_sys_rst_o),
  .ctl_hartsel_o(ctl_hartsel_o), .chal(chal)
);

// File: tb/sim_dbg_auth_gate.sv
module sim_dbg_auth_gate;
  localparam logic [6:0]  CTL  = 7'h10;
  localparam logic [6:0]  AUTH = 7'h30;
  localparam logic [31:0] SEED = 32'h1ACE_B00C;
  localparam logic [31:0] SEC  = 32'h5EC2_E7A1;
  localparam logic [31:0] SEED1 = 32'h0BAD_F00D;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_ST = 2'd2;
  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{OP_RD, CTL,   32'h0,         32'h0,    8'd1},  // R1 control idle
    '{OP_ST, 7'h0,  32'h0,         32'h0,    8'd1},  // R1 not authenticated
    '{OP_RD, AUTH,  32'h0,         SEED,     8'd8},  // R8 challenge = seed
    '{OP_WR, 7'h05, 32'hDEAD_BEEF, 32'h0,    8'd2},  // R2 blocked
    '{OP_WR, CTL,   32'h0000_0F1F, 32'h0,    8'd4},  // R4 unauth fields
    '{OP_RD, CTL,   32'h0,         32'h1,    8'd3},  // R3 active only
    '{OP_WR, AUTH,  SEED + SEC,    32'h0,    8'd6},  // R6 response
    '{OP_ST, 7'h0,  32'h0,         32'h1,    8'd6},
    '{OP_RD, AUTH,  32'h0,         SEED,     8'd6},  // R6 challenge kept
    '{OP_WR, 7'h05, 32'hCAFE_0001, 32'h1,    8'd2},  // R2 forwarded
    '{OP_WR, CTL,   32'h0000_0517, 32'h0,    8'd4},
    '{OP_RD, CTL,   32'h0,         32'h517,  8'd4},  // R4 fields loaded
    '{OP_RD, 7'h22, 32'h0,         32'h0,    8'd8},  // R8 unmapped read
    '{OP_WR, CTL,   32'h0,         32'h0,    8'd5},
    '{OP_RD, CTL,   32'h0,         32'h0,    8'd5},  // R5 fields cleared
    '{OP_ST, 7'h0,  32'h0,         32'h0,    8'd9},  // R9 deactivate drops auth
    '{OP_WR, 7'h05, 32'h1234_5678, 32'h0,    8'd2}   // R2 blocked again
  };

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0;
  logic [6:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, fwd_data, rd_data1, fwd_data1;
  logic fwd_en, authed, act, halt, resm, hrst, srst;
  logic fwd_en1, authed1, act1, halt1, resm1, hrst1, srst1;
  logic [6:0] fwd_addr, fwd_addr1;
  logic [3:0] hsel, hsel1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_auth_gate #(.AUTH_REQ(1'b1), .CTL_ADDR(CTL), .AUTH_ADDR(AUTH), .SEED(SEED), .SECRET(SEC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .fwd_en_o(fwd_en), .fwd_addr_o(fwd_addr),
    .fwd_data_o(fwd_data), .authenticated_o(authed), .ctl_active_o(act), .ctl_halt_o(halt),
    .ctl_resume_o(resm), .ctl_hart_rst_o(hrst), .ctl_sys_rst_o(srst), .ctl_hartsel_o(hsel));

  dbg_auth_gate #(.AUTH_REQ(1'b0), .CTL_ADDR(CTL), .AUTH_ADDR(AUTH), .SEED(SEED1), .SECRET(SEC)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data1), .fwd_en_o(fwd_en1), .fwd_addr_o(fwd_addr1),
    .fwd_data_o(fwd_data1), .authenticated_o(authed1), .ctl_active_o(act1), .ctl_halt_o(halt1),
    .ctl_resume_o(resm1), .ctl_hart_rst_o(hrst1), .ctl_sys_rst_o(srst1), .ctl_hartsel_o(hsel1));

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act_v, exp_v);
    end
  endtask

  // drive at negedge, sample forward mid-cycle, state visible after next posedge
  task automatic wr(input logic [6:0] a, input logic [31:0] d, output logic f, output logic [6:0] fa,
                    output logic [31:0] fd);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    #1 f = fwd_en; fa = fwd_addr; fd = fwd_data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic f; logic [6:0] fa; logic [31:0] fd, d, c;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", TBL[i].req, i);
      case (TBL[i].op)
        OP_WR: begin
          wr(TBL[i].addr, TBL[i].data, f, fa, fd);
          chk(tag, {31'b0, f}, TBL[i].exp);
          if (TBL[i].exp[0]) begin
            chk(tag, {25'b0, fa}, {25'b0, TBL[i].addr});
            chk(tag, fd, TBL[i].data);
          end
        end
        OP_RD: begin rd(TBL[i].addr, d); chk(tag, d, TBL[i].exp); end
        default: chk(tag, {31'b0, authed}, TBL[i].exp);
      endcase
    end

    // R7: failed response regenerates the challenge, which then authenticates
    wr(CTL, 32'h1, f, fa, fd);
    chk("R3 reactivate", {31'b0, act}, 32'h1);
    wr(AUTH, SEED + SEC + 32'h1, f, fa, fd);
    chk("R7 miss clears", {31'b0, authed}, 32'h0);
    rd(AUTH, c);
    checks++;
    if (c == SEED) begin
      errors++;
      $display("FAIL R7: actual 0x%08h expected value other than 0x%08h", c, SEED);
    end
    wr(AUTH, c + SEC, f, fa, fd);
    chk("R7 new challenge accepted", {31'b0, authed}, 32'h1);
    rd(AUTH, d);
    chk("R7 challenge kept on match", d, c);
    wr(CTL, 32'h0000_0A09, f, fa, fd);
    chk("R4 hart reset and hartsel", {24'b0, hsel, hrst, halt, resm, act}, 32'hA9);
    chk("R4 system reset untouched", {31'b0, srst}, 32'h0);

    // R10: open instance saw all of the above
    chk("R10 open status", {31'b0, authed1}, 32'h1);
    rd(AUTH, d);
    chk("R10 open challenge", rd_data1, SEED1);
    wr(7'h05, 32'h0F0F_0F0F, f, fa, fd);
    chk("R10 open forward", {31'b0, fwd_en1}, 32'h1);

    // R1: reset mid-run
    @(negedge clk);
    rst_ni = 0;
    #1;
    chk("R1 status after reset", {31'b0, authed}, 32'h0);
    chk("R1 control after reset", {27'b0, act, halt, resm, hrst, srst}, 32'h0);
    chk("R1 hartsel after reset", {28'b0, hsel}, 32'h0);
    rd(AUTH, d);
    chk("R1 challenge after reset", d, SEED);
    chk("R10 open status in reset", {31'b0, authed1}, 32'h1);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule